// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block sits between fifteen peripheral interrupt request lines and a CPU core. A small write port loads the configuration: per-source enables, a global enable, and two priority bits per source. Each source then sits on one of four levels. On every cycle the block looks at all pending, enabled sources and finds the one on the highest level. A fixed polling order breaks ties within a level. When no request is outstanding, the block latches that winner's vector address and raises a request to the CPU.

The vector and the request hold steady until the CPU acknowledges. On the acknowledge, the granted level is marked as in service. A later source is granted only when its level is strictly above every level in service, which gives nested preemption. A return strobe from the CPU retires the highest in-service level.

Top module: `int_prio_arbiter`

## Requirements
- R1: After reset `irq_req` is 0, `irq_vec` is 0, every enable and priority bit is 0, and no level is in service.
- R2: A write with `cfg_we`=1 loads `cfg_data` at the clock edge into the register picked by `cfg_sel`. The codes are: 0 main enable, 1 timer enable, 2 main priority low, 3 main priority high, 4 timer priority low, 5 timer priority high. In the main bytes, bits 0..6 stand for X0, T0, X1, T1, S0, S1 and ADC, and bit 7 of the main enable is the global enable. In the timer bytes, bits 0..3 stand for CT0..CT3, bits 4..6 for CM0..CM2 and bit 7 for T2.
- R3: While the global enable is 0, no request is raised, whatever the source lines do.
- R4: A source's level is {high bit, low bit}, from 0 to 3. A pending source on a higher level wins over any source on a lower level.
- R5: Among pending sources on one level, the winner is the first in this order: X0, S1, ADC, T0, CT0, CM0, X1, CT1, CM1, T1, CT2, CM2, S0, CT3, T2.
- R6: `src_req` bit i and vector slot i belong to the same source. The slots in order are X0, T0, X1, T1, S0, S1, CT0, CT1, CT2, CT3, ADC, CM0, CM1, CM2, T2. The vector output is 0x03 + 8·i, so X0 gives 0x03 and T2 gives 0x73.
- R7: `irq_req` rises on the clock edge after a qualifying request appears. While it is high and `irq_ack` is low, `irq_vec` does not change, even when a higher-level source arrives.
- R8: At the edge where `irq_ack` meets a raised request, the request drops and the granted level becomes in service. After that, only a source on a strictly higher level is granted. A source on an equal or lower level waits.
- R9: A `reti` strobe clears the highest in-service level at the clock edge. A source that was blocked by that level is granted on the edge that follows.
- R10: A source whose own enable bit is 0 raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_data | input | 8 | Configuration write data |
| src_req | input | 15 | Request lines, indexed by vector slot |
| irq_ack | input | 1 | CPU acknowledge of the presented vector |
| reti | input | 1 | CPU return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 8 | Vector address of the granted source |

## Verification
The bench builds the block with its default parameters: a vector base of 0x03, a step of 8 and an 8-bit vector. With these values every vector from 0x03 to 0x73 can be predicted exactly, and the two ends of the slot range are both reached. The table of configurations sets up ties on a level, contests between the high and low bits, and sources that are masked by their own enable or by the global enable. Directed sequences cover preemption while a vector is held, blocking at an equal level, and retirement of nested levels one return strobe at a time.

// File: rtl/int_arb_pkg.sv
package int_arb_pkg;
  localparam int NSRC  = 15;
  localparam int LVL_W = 2;
  localparam int NLVL  = 1 << LVL_W;
  localparam int SLOT_W = $clog2(NSRC);

  // main byte bits 0..6 and timer byte bits 0..7 to vector slots
  function automatic logic [NSRC-1:0] cfg_to_slots(input logic [6:0] a, input logic [7:0] b);
    logic [NSRC-1:0] r;
    r[4:0]   = a[4:0];
    r[5]     = a[5];
    r[10]    = a[6];
    r[9:6]   = b[3:0];
    r[13:11] = b[6:4];
    r[14]    = b[7];
    return r;
  endfunction

  // polling rank to vector slot: ranks come in groups of three
  function automatic int rank_slot(input int rank);
    return (rank % 3) * 5 + rank / 3;
  endfunction

  // index of highest set in-service flag
  function automatic logic [LVL_W-1:0] top_level(input logic [NLVL-1:0] f);
    logic [LVL_W-1:0] t;
    t = '0;
    for (int i = 0; i < NLVL; i++)
      if (f[i]) t = LVL_W'(i);
    return t;
  endfunction
endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs
  import int_arb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [SEL_W-1:0]      sel,
  input  logic [DATA_W-1:0]     data,
  output logic                  glob_en,
  output logic [NSRC-1:0]       src_en,
  output logic [NSRC-1:0][LVL_W-1:0] src_lvl
);
  logic [7:0] en_main, en_tmr, lo_tmr, hi_tmr;
  logic [6:0] lo_main, hi_main;
  logic [NSRC-1:0] lo_bits, hi_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_main <= '0; en_tmr <= '0; lo_main <= '0;
      hi_main <= '0; lo_tmr <= '0; hi_tmr <= '0;
    end else if (we) begin
      case (sel)
        SEL_W'(0): en_main <= data[7:0];
        SEL_W'(1): en_tmr  <= data[7:0];
        SEL_W'(2): lo_main <= data[6:0];
        SEL_W'(3): hi_main <= data[6:0];
        SEL_W'(4): lo_tmr  <= data[7:0];
        SEL_W'(5): hi_tmr  <= data[7:0];
        default: ;
      endcase
    end
  end

  assign glob_en = en_main[7];
  assign src_en  = cfg_to_slots(en_main[6:0], en_tmr);
  assign lo_bits = cfg_to_slots(lo_main, lo_tmr);
  assign hi_bits = cfg_to_slots(hi_main, hi_tmr);

  for (genvar i = 0; i < NSRC; i++) begin : g_lvl
    assign src_lvl[i] = {hi_bits[i], lo_bits[i]};
  end
endmodule

// File: rtl/arb_select.sv
module arb_select
  import int_arb_pkg::*;
(
  input  logic [NSRC-1:0]            pend,
  input  logic [NSRC-1:0][LVL_W-1:0] src_lvl,
  input  logic                       svc_any,
  input  logic [LVL_W-1:0]           svc_top,
  output logic                       win_valid,
  output logic [SLOT_W-1:0]          win_slot,
  output logic [LVL_W-1:0]           win_lvl
);
  logic found;

  always_comb begin
    found    = 1'b0;
    win_slot = '0;
    win_lvl  = '0;
    for (int r = 0; r < NSRC; r++) begin
      if (pend[rank_slot(r)] && (!found || src_lvl[rank_slot(r)] > win_lvl)) begin
        found    = 1'b1;
        win_slot = SLOT_W'(rank_slot(r));
        win_lvl  = src_lvl[rank_slot(r)];
      end
    end
    win_valid = found && (!svc_any || win_lvl > svc_top);
  end
endmodule

// File: rtl/arb_service.sv
module arb_service
  import int_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [LVL_W-1:0] set_lvl,
  input  logic             clr_top,
  output logic [NLVL-1:0]  svc,
  output logic             svc_any,
  output logic [LVL_W-1:0] svc_top
);
  logic [NLVL-1:0] clr_mask, set_mask;

  assign svc_any = |svc;
  assign svc_top = top_level(svc);

  always_comb begin
    clr_mask = '0;
    set_mask = '0;
    if (clr_top && svc_any) clr_mask[svc_top] = 1'b1;
    if (set_en) set_mask[set_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) svc <= '0;
    else        svc <= (svc & ~clr_mask) | set_mask;
  end

  AST_RETI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_top && !set_en && svc_any) |=> ($countones(svc) == $past($countones(svc)) - 1)); // R9
  AST_SET_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> svc[$past(set_lvl)]); // R8
endmodule

// File: rtl/int_prio_arbiter.sv
module int_prio_arbiter
  import int_arb_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_sel,
  input  logic [7:0]      cfg_data,
  input  logic [14:0]     src_req,
  input  logic            irq_ack,
  input  logic            reti,
  output logic            irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  localparam int VEC_MAX = VEC_BASE + VEC_STEP * (NSRC - 1);

  logic                       glob_en;
  logic [NSRC-1:0]            src_en, pend;
  logic [NSRC-1:0][LVL_W-1:0] src_lvl;
  logic                       win_valid;
  logic [SLOT_W-1:0]          win_slot;
  logic [LVL_W-1:0]           win_lvl, lvl_q, svc_top;
  logic [NLVL-1:0]            svc;
  logic                       svc_any, req_q, grant_take;
  logic [VEC_W-1:0]           vec_q;

  function automatic logic [VEC_W-1:0] slot_vec(input logic [SLOT_W-1:0] s);
    return VEC_W'(VEC_BASE + VEC_STEP * int'(s));
  endfunction

  arb_cfg_regs #(.DATA_W(8), .SEL_W(3)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .data(cfg_data),
    .glob_en(glob_en), .src_en(src_en), .src_lvl(src_lvl));

  assign pend = src_req & src_en & {NSRC{glob_en}};

  arb_select u_sel (
    .pend(pend), .src_lvl(src_lvl), .svc_any(svc_any), .svc_top(svc_top),
    .win_valid(win_valid), .win_slot(win_slot), .win_lvl(win_lvl));

  assign grant_take = req_q && irq_ack;

  arb_service u_svc (
    .clk(clk), .rst_n(rst_n), .set_en(grant_take), .set_lvl(lvl_q),
    .clr_top(reti), .svc(svc), .svc_any(svc_any), .svc_top(svc_top));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= '0;
    end else if (req_q) begin
      if (irq_ack) req_q <= 1'b0;
    end else if (win_valid) begin
      req_q <= 1'b1;
      vec_q <= slot_vec(win_slot);
      lvl_q <= win_lvl;
    end
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !irq_ack) |=> (req_q && $stable(vec_q) && $stable(lvl_q))); // R7
  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && irq_ack) |=> !req_q); // R8
  AST_GRANT_ABOVE_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (!svc_any || lvl_q > svc_top)); // R8
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(glob_en)); // R3
  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (int'(vec_q) >= VEC_BASE && int'(vec_q) <= VEC_MAX)); // R6
endmodule

// File: tb/int_prio_arbiter_tb.sv
`timescale 1ns/1ps
module int_prio_arbiter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [7:0] cfg_data = '0;
  logic [14:0] src_req = '0;
  logic irq_ack = 1'b0, reti = 1'b0;
  logic irq_req;
  logic [7:0] irq_vec;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  int_prio_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .src_req(src_req), .irq_ack(irq_ack),
    .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec));

  // {tag, enMain, enTmr, loMain, hiMain, loTmr, hiTmr, src, expReq, expVec}
  localparam int NV = 14;
  localparam logic [79:0] TBL [NV] = '{
    {8'd6,  8'h81, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 15'h0001, 1'b1, 8'h03}, // R6 X0
    {8'd5,  8'hC0, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 15'h4400, 1'b1, 8'h53}, // R5 ADC over T2
    {8'd5,  8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 15'h7FFF, 1'b1, 8'h03}, // R5 all
    {8'd4,  8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h80, 15'h7FFF, 1'b1, 8'h73}, // R4 T2 lvl2
    {8'd5,  8'hFF, 8'hFF, 8'h40, 8'h00, 8'h80, 8'h00, 15'h7FFF, 1'b1, 8'h53}, // R5 lvl1 tie
    {8'd3,  8'h7F, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 15'h7FFF, 1'b0, 8'h00}, // R3
    {8'd10, 8'hFE, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 15'h0001, 1'b0, 8'h00}, // R10
    {8'd5,  8'h80, 8'h11, 8'h00, 8'h00, 8'h00, 8'h00, 15'h0840, 1'b1, 8'h33}, // R5 CT0/CM0
    {8'd6,  8'h80, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 15'h2000, 1'b1, 8'h6B}, // R6 CM2
    {8'd4,  8'h91, 8'h00, 8'h10, 8'h10, 8'h00, 8'h00, 15'h0011, 1'b1, 8'h23}, // R4 S0 lvl3
    {8'd4,  8'h84, 8'h02, 8'h04, 8'h00, 8'h00, 8'h02, 15'h0084, 1'b1, 8'h3B}, // R4 hi>lo
    {8'd2,  8'hA0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 15'h0020, 1'b1, 8'h2B}, // R2 S1
    {8'd5,  8'h88, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 15'h1008, 1'b1, 8'h63}, // R5 CM1/T1
    {8'd5,  8'h90, 8'h08, 8'h00, 8'h00, 8'h00, 8'h00, 15'h0210, 1'b1, 8'h23}  // R5 S0/CT3
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src_req = '0; irq_ack = 1'b0; reti = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic check(input string tag, input logic er, input logic [7:0] ev);
    n_chk++;
    if (irq_req !== er || (er && irq_vec !== ev) || (!er && ev == 8'h00 && irq_vec !== 8'h00 && tag == "R1")) begin
      n_bad++;
      $display("FAIL %s: req=%0b vec=%02h expected req=%0b vec=%02h", tag, irq_req, irq_vec, er, ev);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1", 1'b0, 8'h00);
    n_chk++;
    if (irq_vec !== 8'h00) begin n_bad++; $display("FAIL R1: vec=%02h expected 00", irq_vec); end
    src_req = 15'h7FFF; tick();
    check("R1", 1'b0, 8'h00); // all disabled after reset
    src_req = '0;

    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(3'd0, TBL[i][71:64]); wr(3'd1, TBL[i][63:56]);
      wr(3'd2, TBL[i][55:48]); wr(3'd3, TBL[i][47:40]);
      wr(3'd4, TBL[i][39:32]); wr(3'd5, TBL[i][31:24]);
      src_req = TBL[i][23:9];
      tick();
      check($sformatf("R%0d", TBL[i][79:72]), TBL[i][8], TBL[i][7:0]);
      src_req = '0;
    end

    // nesting: X0 on level 3, X1 on level 1
    do_reset();
    wr(3'd0, 8'h85); wr(3'd2, 8'h05); wr(3'd3, 8'h01);
    src_req = 15'h0004; tick();
    check("R7", 1'b1, 8'h13);
    src_req = 15'h0005; tick(); tick();
    check("R7", 1'b1, 8'h13); // held despite higher arrival
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    check("R8", 1'b0, 8'h00);
    tick();
    check("R8", 1'b1, 8'h03); // level 3 preempts level 1
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    src_req = 15'h0004; tick(); tick();
    check("R8", 1'b0, 8'h00); // equal level 1 blocked
    reti = 1'b1; tick(); reti = 1'b0;
    check("R9", 1'b0, 8'h00); // level 1 still in service
    tick();
    check("R9", 1'b0, 8'h00);
    reti = 1'b1; tick(); reti = 1'b0;
    check("R9", 1'b0, 8'h00);
    tick();
    check("R9", 1'b1, 8'h13); // released after last retire
    src_req = '0;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule